// File: doc/BRIEF.md
# Edge Timestamp Capture Engine

The engine watches a set of input lines, grouped into slices of 32, and records when they change. Every line first passes through a two-flop synchronizer. Each slice keeps a registered copy of the line values it last accepted. When any line that software has enabled in a slice differs from that copy, the engine stores one event record in a FIFO. The record holds a snapshot of a free-running 64-bit tick counter, the slice number, and the slice's previous and current enabled-line values. Software XORs the previous and current words to find every line that switched at that instant. A global line number is the slice index times 32, plus the bit position inside the slice.

Software uses a small word-addressed register window. Through it, software configures the engine, sets the per-slice line masks, reads the head record and pops it, and watches the FIFO fill level. An interrupt output stays high while the number of stored records is at or above a programmable threshold. The tick counter advances once per block clock, so the block is meant to run from the timestamp clock itself (31.25 MHz, which gives 32 ns per tick).

Top module: `edge_ts_engine`

## Requirements
- R1: After reset, every readable register returns 0, the FIFO holds no records, the head fields (0x04, 0x08, 0x0C, 0x10, 0x14) read 0, and `irq` is low.
- R2: When an enabled line toggles, exactly one record is stored. Register 0x0C bits 23:16 give its slice. Register 0x10 gives the current enabled-line word and register 0x14 gives the previous one, and their XOR has exactly the toggled bit set.
- R3: A line whose mask bit is 0 produces no record. Later records from that slice do not show it as changed, even after it is enabled again.
- R4: Control register 0x00 bit 0 is the engine enable. While it is 0, line changes store nothing. Turning it back on does not report changes that happened while it was off.
- R5: When several slices change in the same cycle, the lowest-numbered slice is stored first and the others follow on later cycles, one record per clock. Their timestamps therefore differ by 1.
- R6: The tick counter advances by one every clock. Register 0x04 gives the head record's upper 32 bits and register 0x08 its lower 32 bits. Two records stored N cycles apart differ by exactly N.
- R7: Status register 0x20 bits 15:8 hold the number of stored records. Writing command register 0x1C with bit 0 set removes the head record. A remove request while the FIFO is empty is ignored.
- R8: A change that finds the FIFO full is dropped, and status bit 0 latches to 1. Writing the command register with bit 1 set clears that bit. The FIFO contents are unaffected.
- R9: `irq` is high exactly when control bit 0, control bit 1 and the condition "occupancy is at least the threshold in control bits 15:8" all hold. A threshold of 0 acts as 1.
- R10: The mask for slice s sits at address 0x40 + 0x20*s, and bit n of it enables line 32*s + n. A record for that line reports slice s with bit n changed.
- R11: Several lines of one slice that toggle in the same cycle produce a single record whose XOR shows all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the timestamp tick |
| rst | input | 1 | Synchronous active-high reset |
| lines_in | input | NUM_SLICES*32 | Asynchronous input lines, line 32*s+n at bit 32*s+n |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Occupancy-threshold interrupt |

## Verification
The bench builds the engine with two slices and a four-record FIFO. The 64-line sweep therefore visits every line and both mask registers, and the overflow path is reached after only four stored events. Timestamps are checked as differences between records whose spacing is chosen by the stimulus, which keeps the expected values arithmetic. Simultaneous multi-slice and multi-line toggles, masked lines, the engine-off window and each interrupt threshold case are each driven and compared against a line-state model held in the bench.

// File: rtl/edge_ts_pkg.sv
package edge_ts_pkg;

    localparam int LINES_PER_SLICE = 32;
    localparam int TS_W            = 64;
    localparam int SLICE_ID_W      = 8;
    localparam int REG_ADDR_W      = 8;

    typedef logic [LINES_PER_SLICE-1:0] word_t;

    typedef struct packed {
        logic [TS_W-1:0]       stamp;
        logic [SLICE_ID_W-1:0] slice;
        word_t                 prev;
        word_t                 cur;
    } evt_rec_t;

    typedef struct packed {
        logic [7:0] thr;
        logic       irq_en;
        logic       eng_en;
    } ctrl_t;

    localparam logic [REG_ADDR_W-1:0] ADR_CTRL   = 8'h00;
    localparam logic [REG_ADDR_W-1:0] ADR_TS_HI  = 8'h04;
    localparam logic [REG_ADDR_W-1:0] ADR_TS_LO  = 8'h08;
    localparam logic [REG_ADDR_W-1:0] ADR_SRC    = 8'h0C;
    localparam logic [REG_ADDR_W-1:0] ADR_CUR    = 8'h10;
    localparam logic [REG_ADDR_W-1:0] ADR_PREV   = 8'h14;
    localparam logic [REG_ADDR_W-1:0] ADR_CMD    = 8'h1C;
    localparam logic [REG_ADDR_W-1:0] ADR_STATUS = 8'h20;

    // Threshold 0 behaves as 1
    function automatic logic [7:0] eff_thr(input logic [7:0] t);
        return (t == 8'd0) ? 8'd1 : t;
    endfunction

    // Mask register address for slice s
    function automatic logic [REG_ADDR_W-1:0] mask_addr(input int s);
        return REG_ADDR_W'(8'h40 + 8'h20 * s);
    endfunction

endpackage

// File: rtl/edge_ts_sync.sv
module edge_ts_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/edge_ts_fifo.sv
module edge_ts_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign dout  = mem[rd_q];

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            if (push) wr_q <= nxt(wr_q);
            if (pop)  rd_q <= nxt(rd_q);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/edge_ts_detect.sv
module edge_ts_detect
    import edge_ts_pkg::*;
#(
    parameter int NUM_SLICES = 3,
    localparam int NL = NUM_SLICES * LINES_PER_SLICE
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  eng_en,
    input  logic                  fifo_full,
    input  logic [NL-1:0]         lines,
    input  logic [NL-1:0]         en_mask,
    output logic                  push,
    output logic                  drop,
    output logic [NUM_SLICES-1:0] grant,
    output logic [SLICE_ID_W-1:0] slice_id,
    output word_t                 prev_val,
    output word_t                 cur_val
);
    localparam int L = LINES_PER_SLICE;

    logic [NL-1:0]         last_q;
    logic [NUM_SLICES-1:0] changed;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        word_t now_w, last_w, en_w;
        assign now_w  = lines[s*L +: L];
        assign last_w = last_q[s*L +: L];
        assign en_w   = en_mask[s*L +: L];
        assign changed[s] = eng_en && (|((now_w ^ last_w) & en_w));

        always_ff @(posedge clk) begin
            if (rst)
                last_q[s*L +: L] <= '0;
            else if (!eng_en || grant[s] || (changed[s] && fifo_full))
                last_q[s*L +: L] <= now_w;
            else
                last_q[s*L +: L] <= (last_w & en_w) | (now_w & ~en_w);
        end
    end

    // Lowest-numbered changed slice wins; others stay pending
    always_comb begin
        logic found;
        found    = 1'b0;
        grant    = '0;
        slice_id = '0;
        prev_val = '0;
        cur_val  = '0;
        for (int s = 0; s < NUM_SLICES; s++) begin
            if (changed[s] && !found && !fifo_full) begin
                found    = 1'b1;
                grant[s] = 1'b1;
                slice_id = SLICE_ID_W'(s);
                prev_val = last_q[s*L +: L] & en_mask[s*L +: L];
                cur_val  = lines[s*L +: L]  & en_mask[s*L +: L];
            end
        end
    end

    assign push = |grant;
    assign drop = fifo_full && (|changed);
endmodule

// File: rtl/edge_ts_engine.sv
module edge_ts_engine
    import edge_ts_pkg::*;
#(
    parameter int NUM_SLICES = 3,
    parameter int FIFO_DEPTH = 16,
    localparam int NL    = NUM_SLICES * LINES_PER_SLICE,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NL-1:0]         lines_in,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  irq
);
    localparam int L = LINES_PER_SLICE;

    ctrl_t                 ctrl_q;
    logic [NL-1:0]         mask_q;
    logic [TS_W-1:0]       tick_q;
    logic                  ovf_q;
    logic [NL-1:0]         lines_s;
    logic                  evt_push, evt_pop, evt_drop, fifo_full, fifo_empty;
    logic [NUM_SLICES-1:0] slice_grant;
    logic [CNT_W-1:0]      fifo_count;
    logic [SLICE_ID_W-1:0] det_slice;
    word_t                 det_prev, det_cur;
    evt_rec_t              rec_in, rec_head;
    logic                  eng_en_w, irq_en_w, ovf_clr_w, cmd_wr;
    logic [7:0]            occ8;

    assign eng_en_w  = ctrl_q.eng_en;
    assign irq_en_w  = ctrl_q.irq_en;
    assign cmd_wr    = bus_wr && (bus_addr == ADR_CMD);
    assign evt_pop   = cmd_wr && bus_wdata[0] && !fifo_empty;
    assign ovf_clr_w = cmd_wr && bus_wdata[1];
    assign occ8      = 8'(fifo_count);

    edge_ts_sync #(.W(NL)) u_sync (
        .clk(clk), .rst(rst), .d(lines_in), .q(lines_s)
    );

    edge_ts_detect #(.NUM_SLICES(NUM_SLICES)) u_det (
        .clk(clk), .rst(rst), .eng_en(eng_en_w), .fifo_full(fifo_full),
        .lines(lines_s), .en_mask(mask_q), .push(evt_push), .drop(evt_drop),
        .grant(slice_grant), .slice_id(det_slice),
        .prev_val(det_prev), .cur_val(det_cur)
    );

    assign rec_in = '{stamp: tick_q, slice: det_slice, prev: det_prev, cur: det_cur};

    edge_ts_fifo #(.DEPTH(FIFO_DEPTH), .W($bits(evt_rec_t))) u_fifo (
        .clk(clk), .rst(rst), .push(evt_push), .pop(evt_pop),
        .din(rec_in), .dout(rec_head), .count(fifo_count),
        .full(fifo_full), .empty(fifo_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            tick_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            tick_q <= tick_q + 1'b1;
            if (bus_wr && bus_addr == ADR_CTRL)
                ctrl_q <= '{thr: bus_wdata[15:8], irq_en: bus_wdata[1], eng_en: bus_wdata[0]};
            if (evt_drop)       ovf_q <= 1'b1;
            else if (ovf_clr_w) ovf_q <= 1'b0;
        end
    end

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst)
                mask_q[s*L +: L] <= '0;
            else if (bus_wr && bus_addr == mask_addr(s))
                mask_q[s*L +: L] <= bus_wdata;
        end
    end

    always_comb begin
        evt_rec_t h;
        h = fifo_empty ? '0 : rec_head;
        bus_rdata = '0;
        case (bus_addr)
            ADR_CTRL:   bus_rdata = {16'd0, ctrl_q.thr, 6'd0, ctrl_q.irq_en, ctrl_q.eng_en};
            ADR_TS_HI:  bus_rdata = h.stamp[63:32];
            ADR_TS_LO:  bus_rdata = h.stamp[31:0];
            ADR_SRC:    bus_rdata = {8'd0, h.slice, 16'd0};
            ADR_CUR:    bus_rdata = h.cur;
            ADR_PREV:   bus_rdata = h.prev;
            ADR_STATUS: bus_rdata = {16'd0, occ8, 7'd0, ovf_q};
            default: begin
                for (int s = 0; s < NUM_SLICES; s++)
                    if (bus_addr == mask_addr(s)) bus_rdata = mask_q[s*L +: L];
            end
        endcase
    end

    assign irq = eng_en_w && irq_en_w && (occ8 >= eff_thr(ctrl_q.thr));
endmodule

// File: rtl/edge_ts_checker.sv
module edge_ts_checker #(
    parameter int NUM_SLICES = 3,
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  push,
    input logic                  pop,
    input logic                  drop,
    input logic                  full,
    input logic [CNT_W-1:0]      count,
    input logic [NUM_SLICES-1:0] grant,
    input logic                  eng_en,
    input logic                  irq_en,
    input logic                  irq,
    input logic                  ovf,
    input logic                  ovf_clr
);
    AST_OCC_BOUND:     assert property (@(posedge clk) disable iff (rst) count <= CNT_W'(FIFO_DEPTH)); // R8
    AST_PUSH_ROOM:     assert property (@(posedge clk) disable iff (rst) push |-> !full); // R8
    AST_IDLE_STABLE:   assert property (@(posedge clk) disable iff (rst) (!push && !pop) |=> $stable(count)); // R7
    AST_POP_DEC:       assert property (@(posedge clk) disable iff (rst) (pop && !push) |=> count == $past(count) - 1'b1); // R7
    AST_GRANT_SINGLE:  assert property (@(posedge clk) disable iff (rst) $onehot0(grant)); // R5
    AST_NO_CAPTURE:    assert property (@(posedge clk) disable iff (rst) !eng_en |-> (!push && !drop)); // R4
    AST_IRQ_QUAL:      assert property (@(posedge clk) disable iff (rst) irq |-> (eng_en && irq_en && count != '0)); // R9
    AST_OVF_STICKY:    assert property (@(posedge clk) disable iff (rst) (ovf && !ovf_clr) |=> ovf); // R8
    AST_DROP_FLAGS:    assert property (@(posedge clk) disable iff (rst) drop |=> ovf); // R8
endmodule

bind edge_ts_engine edge_ts_checker #(
    .NUM_SLICES(NUM_SLICES),
    .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
    .clk(clk), .rst(rst), .push(evt_push), .pop(evt_pop), .drop(evt_drop),
    .full(fifo_full), .count(fifo_count), .grant(slice_grant),
    .eng_en(eng_en_w), .irq_en(irq_en_w), .irq(irq), .ovf(ovf_q), .ovf_clr(ovf_clr_w)
);

// File: tb/edge_ts_engine_test.sv
module edge_ts_engine_test;
    localparam int SL  = 2;
    localparam int DEP = 4;
    localparam int NL  = SL * 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] lines_in = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq;

    logic [NL-1:0] lv = '0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    edge_ts_engine #(.NUM_SLICES(SL), .FIFO_DEPTH(DEP)) uut (
        .clk(clk), .rst(rst), .lines_in(lines_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic flip(input int i);
        lv[i] = ~lv[i];
        lines_in = lv;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic occ(output int n);
        logic [31:0] d;
        rd(8'h20, d);
        n = int'(d[15:8]);
    endtask

    task automatic head(output int sl, output logic [31:0] pv, output logic [31:0] cv,
                        output logic [63:0] ts);
        logic [31:0] d, hi;
        rd(8'h0C, d);  sl = int'(d[23:16]);
        rd(8'h14, pv);
        rd(8'h10, cv);
        rd(8'h04, hi);
        rd(8'h08, d);
        ts = {hi, d};
    endtask

    task automatic pop();
        wr(8'h1C, 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, pv, cv;
        logic [63:0] t0, t1, t2;
        int sl, n;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, d); chk("R1 ctrl", d, 0);
        rd(8'h20, d); chk("R1 status", d, 0);
        rd(8'h40, d); chk("R1 mask0", d, 0);
        rd(8'h60, d); chk("R1 mask1", d, 0);
        rd(8'h10, d); chk("R1 head cur", d, 0);
        rd(8'h08, d); chk("R1 head ts", d, 0);
        chk("R1 irq", irq, 0);

        // R10 mask addresses
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h60, 32'hFFFF_FFFF);
        rd(8'h60, d); chk("R10 mask1 readback", d, 32'hFFFF_FFFF);
        wr(8'h00, 32'h0000_0203);
        rd(8'h00, d); chk("R9 ctrl readback", d, 32'h203);

        // R2 single line, R9 threshold 2
        @(negedge clk); flip(5); settle();
        occ(n); chk("R2 occupancy", n, 1);
        head(sl, pv, cv, t0);
        chk("R2 slice", sl, 0);
        chk("R2 xor", pv ^ cv, 32'h20);
        chk("R2 cur", cv, lv[31:0]);
        chk("R9 below threshold", irq, 0);
        pop();
        occ(n); chk("R7 pop", n, 0);

        // R5 + R11 simultaneous slices
        @(negedge clk); flip(0); flip(31); flip(40); settle();
        occ(n); chk("R5 two records", n, 2);
        chk("R9 at threshold", irq, 1);
        head(sl, pv, cv, t0);
        chk("R5 first slice", sl, 0);
        chk("R11 multi-line xor", pv ^ cv, 32'h8000_0001);
        pop();
        head(sl, pv, cv, t1);
        chk("R5 second slice", sl, 1);
        chk("R5 second xor", pv ^ cv, 32'h100);
        chk("R5 stamp gap", t1 - t0, 1);
        pop();

        // R6 timestamp spacing
        @(negedge clk); flip(1);
        repeat (3) @(negedge clk); flip(2);
        repeat (5) @(negedge clk); flip(3);
        settle();
        head(sl, pv, cv, t0); pop();
        head(sl, pv, cv, t1); chk("R6 xor second", pv ^ cv, 32'h4); pop();
        head(sl, pv, cv, t2); pop();
        chk("R6 gap 3", t1 - t0, 3);
        chk("R6 gap 5", t2 - t1, 5);
        chk("R6 upper word", t2[63:32], 0);

        // R3 masked line
        wr(8'h60, ~32'h8);
        @(negedge clk); flip(35); settle();
        occ(n); chk("R3 masked no record", n, 0);
        wr(8'h60, 32'hFFFF_FFFF);
        settle();
        occ(n); chk("R3 re-enable no record", n, 0);
        @(negedge clk); flip(36); settle();
        head(sl, pv, cv, t0);
        chk("R3 xor excludes masked line", pv ^ cv, 32'h10);
        chk("R3 cur", cv, lv[63:32]);
        pop();

        // R8 overflow
        for (int k = 10; k < 15; k++) begin
            @(negedge clk); flip(k); settle();
        end
        rd(8'h20, d);
        chk("R8 status full+ovf", d, 32'h0000_0401);
        head(sl, pv, cv, t0);
        chk("R8 oldest kept", pv ^ cv, 32'h400);
        for (int k = 0; k < 4; k++) pop();
        rd(8'h20, d); chk("R8 sticky after drain", d, 32'h1);
        wr(8'h1C, 32'h2);
        rd(8'h20, d); chk("R8 cleared", d, 0);
        pop();
        rd(8'h20, d); chk("R7 pop on empty ignored", d, 0);

        // R9 threshold zero, irq enable off
        wr(8'h00, 32'h0000_0003);
        @(negedge clk); flip(20); settle();
        chk("R9 thr0 acts as 1", irq, 1);
        wr(8'h00, 32'h0000_0001);
        chk("R9 irq disabled", irq, 0);
        pop();

        // R4 engine off
        wr(8'h00, 32'h0000_0000);
        @(negedge clk); flip(50); flip(7); settle();
        occ(n); chk("R4 off no record", n, 0);
        wr(8'h00, 32'h0000_0001);
        settle();
        occ(n); chk("R4 no stale report", n, 0);

        // R10 sweep over every line
        for (int i = 0; i < NL; i++) begin
            @(negedge clk); flip(i); settle();
            head(sl, pv, cv, t0);
            chk("R10 sweep slice", sl, i / 32);
            chk("R10 sweep xor", pv ^ cv, 64'(32'h1 << (i % 32)));
            chk("R2 sweep cur", cv, (i < 32) ? lv[31:0] : lv[63:32]);
            pop();
        end
        occ(n); chk("R7 drained", n, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule